// File: doc/BRIEF.md
# SIMT Wavefront Spawn and Barrier Scheduler

This block holds the wavefront contexts of one SIMT core and decides, every cycle, which of them fetch serves next. Each context carries a live flag, a program counter and a per-thread execution mask. After reset only context 0 is live, and it starts at an address supplied on an input pin. A decoded spawn request brings further contexts to life at one shared start address. A decoded barrier request parks the wavefront that issued it until enough wavefronts have reached the same barrier id. At that point every wavefront parked on that id is freed in the same cycle.

The pipeline reports PC changes through a single write port: a sequential advance or a redirect, both applied the same way. A stall input freezes the rotation of the picker without changing any context state. The outputs name the chosen wavefront together with its PC and mask. They are driven from registered state through combinational logic, so any change made at a clock edge shows up on the outputs right after that edge.

Top module: `wf_sched`

## Requirements
- R1: While rst_n is low at a clock edge, context 0 becomes live with PC equal to reset_pc and an all-ones mask. Every other context becomes not live, all barrier waits and arrival counts clear, and the first pick after reset is context 0.
- R2: A spawn with count n makes contexts 1 to n-1 live, with PC equal to spawn_pc and an all-ones mask. Context 0 is never touched by a spawn. A count of 0 or 1 changes nothing. On a context that the spawn writes, the spawn wins over a PC update in the same cycle.
- R3: A spawn count greater than NUM_WF is treated as NUM_WF.
- R4: An update writes upd_pc into context upd_wf when that context is live. An update aimed at a context that is not live has no effect.
- R5: An accepted barrier arrival that leaves the arrival count of its id below bar_expect parks the issuer. A parked wavefront is never picked.
- R6: When an accepted arrival brings the count of its id to bar_expect or above, every wavefront parked on that id is freed in that cycle, the issuer is not parked, and the count of that id restarts from zero.
- R7: The pick is the first eligible context (live and not parked) in the order last+1, last+2, and so on, wrapping modulo NUM_WF, where last is the most recent pick made while stall was low.
- R8: While stall is high, the stored last pick does not change. With unchanged eligibility, the same context stays on the outputs.
- R9: With no eligible context, sel_valid is 0.
- R10: A barrier request from a context that is not live, or that is already parked, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_pc | input | PC_W | Start address of context 0 after reset |
| spawn_valid | input | 1 | Spawn request this cycle |
| spawn_count | input | PC_W | Requested number of wavefronts (first operand) |
| spawn_pc | input | PC_W | Start address for spawned contexts (second operand) |
| bar_valid | input | 1 | Barrier arrival this cycle |
| bar_wf | input | WF_W | Wavefront issuing the barrier |
| bar_id | input | BAR_W | Barrier id |
| bar_expect | input | CNT_W | Number of arrivals that frees the barrier |
| upd_valid | input | 1 | PC advance or redirect this cycle |
| upd_wf | input | WF_W | Wavefront whose PC is written |
| upd_pc | input | PC_W | New PC |
| stall | input | 1 | Freeze the round-robin pointer |
| sel_valid | output | 1 | A wavefront is picked |
| sel_wf | output | WF_W | Picked wavefront id |
| sel_pc | output | PC_W | PC of the picked wavefront |
| sel_mask | output | THREADS | Thread mask of the picked wavefront |

## Verification
The bench builds the block with four contexts, four barrier ids, eight threads and 32-bit PCs. With these values, a spawn count of up to nine passes well beyond the clamp, and every context can be parked at once, so the idle output appears. The random traffic uses only two barrier ids, which makes interleaved barriers and releases frequent, and a periodic reset lets the run recover from any deadlock that interleaved barriers create.

// File: rtl/wf_pkg.sv
// Shared helpers for the wavefront scheduler.
// Assumes callers pass a table size of at least two.
package wf_pkg;

    // Smallest table the scheduler supports.
    localparam int unsigned WF_MIN = 2;

    // Slot visited at step k of a round-robin scan that starts after 'last'.
    function automatic int unsigned rr_slot(input int unsigned last,
                                            input int unsigned k,
                                            input int unsigned n);
        return (last + k) % n;
    endfunction

endpackage

// File: rtl/wf_table.sv
// Wavefront context table: one live flag, PC and thread mask per context.
// Handles reset of context 0, spawn (with count clamping) and PC updates.
// Assumes NUM_WF >= 2; spawn never touches context 0.
module wf_table #(
    parameter int NUM_WF  = 4,
    parameter int PC_W    = 32,
    parameter int THREADS = 8,
    localparam int WF_W   = $clog2(NUM_WF),
    localparam int CNT_W  = $clog2(NUM_WF + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PC_W-1:0]      reset_pc,
    input  logic                 spawn_valid,
    input  logic [PC_W-1:0]      spawn_count,
    input  logic [PC_W-1:0]      spawn_pc,
    input  logic                 upd_valid,
    input  logic [WF_W-1:0]      upd_wf,
    input  logic [PC_W-1:0]      upd_pc,
    output logic [NUM_WF-1:0]    live_q,
    output logic [PC_W-1:0]      pc_q   [NUM_WF],
    output logic [THREADS-1:0]   mask_q [NUM_WF]
);

    logic [CNT_W-1:0] spawn_n;

    // Clamp the requested spawn count to the table size.
    always_comb begin
        if (spawn_count > PC_W'(NUM_WF)) spawn_n = CNT_W'(NUM_WF);
        else                             spawn_n = CNT_W'(spawn_count);
    end

    for (genvar w = 0; w < NUM_WF; w++) begin : g_ctx
        if (w == 0) begin : g_home
            // Context 0: live from reset, only PC updates afterwards.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    live_q[w] <= 1'b1;
                    pc_q[w]   <= reset_pc;
                    mask_q[w] <= '1;
                end else if (upd_valid && upd_wf == WF_W'(w) && live_q[w]) begin
                    pc_q[w] <= upd_pc;
                end
            end
        end else begin : g_spawned
            logic hit;
            // This context is inside the spawned range.
            assign hit = spawn_valid && (CNT_W'(w) < spawn_n);

            // Other contexts: spawn has priority over a PC update.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    live_q[w] <= 1'b0;
                    pc_q[w]   <= '0;
                    mask_q[w] <= '0;
                end else if (hit) begin
                    live_q[w] <= 1'b1;
                    pc_q[w]   <= spawn_pc;
                    mask_q[w] <= '1;
                end else if (upd_valid && upd_wf == WF_W'(w) && live_q[w]) begin
                    pc_q[w] <= upd_pc;
                end
            end
        end
    end

    // R2: a spawn of two or more starts context 1 at the spawn PC, all lanes on.
    a_r2_spawn_start: assert property (@(posedge clk) disable iff (!rst_n)
        (spawn_valid && spawn_count >= PC_W'(2)) |=>
            (live_q[1] && mask_q[1] == '1 && pc_q[1] == $past(spawn_pc)));

    // R3: an oversized count makes the last context live.
    a_r3_clamp_top: assert property (@(posedge clk) disable iff (!rst_n)
        (spawn_valid && spawn_count > PC_W'(NUM_WF)) |=> live_q[NUM_WF-1]);

    // R4: an update aimed at a context that is not live leaves its PC alone.
    a_r4_dead_update: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !live_q[upd_wf] && !spawn_valid) |=>
            (pc_q[$past(upd_wf)] == $past(pc_q[upd_wf])));

endmodule

// File: rtl/wf_barrier.sv
// Barrier table: per barrier id, the set of parked wavefronts and an
// arrival counter. An arrival that reaches the expected count frees the
// whole set and restarts the counter in the same cycle.
// Assumes at most one barrier request per cycle.
module wf_barrier #(
    parameter int NUM_WF  = 4,
    parameter int NUM_BAR = 4,
    localparam int WF_W   = $clog2(NUM_WF),
    localparam int BAR_W  = $clog2(NUM_BAR),
    localparam int CNT_W  = $clog2(NUM_WF + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_WF-1:0]  live,
    input  logic               bar_valid,
    input  logic [WF_W-1:0]    bar_wf,
    input  logic [BAR_W-1:0]   bar_id,
    input  logic [CNT_W-1:0]   bar_expect,
    output logic [NUM_WF-1:0]  parked
);

    logic [NUM_WF-1:0] waiters_q [NUM_BAR];
    logic [CNT_W-1:0]  arrived_q [NUM_BAR];
    logic              accept;
    logic              release_now;
    logic [CNT_W:0]    next_cnt;
    logic [NUM_WF-1:0] freed_set;

    // Union of all barrier wait sets is the per-wavefront park flag.
    always_comb begin
        parked = '0;
        for (int b = 0; b < NUM_BAR; b++) parked = parked | waiters_q[b];
    end

    // Accept only live, unparked issuers; decide whether this arrival frees the id.
    always_comb begin
        accept      = bar_valid && live[bar_wf] && !parked[bar_wf];
        next_cnt    = {1'b0, arrived_q[bar_id]} + 1'b1;
        release_now = accept && (next_cnt >= {1'b0, bar_expect});
        freed_set   = release_now ? waiters_q[bar_id] : '0;
    end

    for (genvar b = 0; b < NUM_BAR; b++) begin : g_bar
        // Per-id wait set and arrival count.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                waiters_q[b] <= '0;
                arrived_q[b] <= '0;
            end else if (accept && bar_id == BAR_W'(b)) begin
                if (release_now) begin
                    waiters_q[b] <= '0;
                    arrived_q[b] <= '0;
                end else begin
                    waiters_q[b] <= waiters_q[b] | (NUM_WF'(1) << bar_wf);
                    arrived_q[b] <= next_cnt[CNT_W-1:0];
                end
            end
        end
    end

    // R5: a non-final arrival parks its issuer.
    a_r5_issuer_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !release_now) |=> parked[$past(bar_wf)]);

    // R6: a final arrival frees every wavefront that waited on that id.
    a_r6_release_all: assert property (@(posedge clk) disable iff (!rst_n)
        release_now |=> ((parked & $past(freed_set)) == '0));

    // R10: a request from a dead or parked wavefront changes no park flag.
    a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_valid && (!live[bar_wf] || parked[bar_wf])) |=> $stable(parked));

endmodule

// File: rtl/wf_rr_pick.sv
// Round-robin picker over the eligible vector. The scan starts just after
// the last pick taken while stall was low.
// Assumes eligibility is already masked for live and not parked.
module wf_rr_pick #(
    parameter int NUM_WF = 4,
    localparam int WF_W  = $clog2(NUM_WF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_WF-1:0]  eligible,
    input  logic               stall,
    output logic               sel_valid,
    output logic [WF_W-1:0]    sel_wf
);
    import wf_pkg::*;

    logic [WF_W-1:0] last_q;

    // Scan from last+1 around the table and take the first eligible slot.
    always_comb begin
        sel_valid = 1'b0;
        sel_wf    = '0;
        for (int k = 1; k <= NUM_WF; k++) begin
            int unsigned idx;
            idx = rr_slot(int'(last_q), k, NUM_WF);
            if (!sel_valid && eligible[idx]) begin
                sel_valid = 1'b1;
                sel_wf    = WF_W'(idx);
            end
        end
    end

    // Remember the pick only while the pipeline accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  last_q <= WF_W'(NUM_WF - 1);
        else if (!stall && sel_valid) last_q <= sel_wf;
    end

    // R7: the pick is always an eligible slot.
    a_r7_pick_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> eligible[sel_wf]);

    // R9: nothing eligible means no pick.
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (eligible == '0) |-> !sel_valid);

endmodule

// File: rtl/wf_sched.sv
// Top of the wavefront scheduler: joins the context table, the barrier
// table and the round-robin picker, and drives the fetch-side outputs.
// Assumes decoded requests arrive at most one of each kind per cycle.
module wf_sched #(
    parameter int NUM_WF  = 4,
    parameter int NUM_BAR = 4,
    parameter int PC_W    = 32,
    parameter int THREADS = 8,
    localparam int WF_W   = $clog2(NUM_WF),
    localparam int BAR_W  = $clog2(NUM_BAR),
    localparam int CNT_W  = $clog2(NUM_WF + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PC_W-1:0]    reset_pc,
    input  logic               spawn_valid,
    input  logic [PC_W-1:0]    spawn_count,
    input  logic [PC_W-1:0]    spawn_pc,
    input  logic               bar_valid,
    input  logic [WF_W-1:0]    bar_wf,
    input  logic [BAR_W-1:0]   bar_id,
    input  logic [CNT_W-1:0]   bar_expect,
    input  logic               upd_valid,
    input  logic [WF_W-1:0]    upd_wf,
    input  logic [PC_W-1:0]    upd_pc,
    input  logic               stall,
    output logic               sel_valid,
    output logic [WF_W-1:0]    sel_wf,
    output logic [PC_W-1:0]    sel_pc,
    output logic [THREADS-1:0] sel_mask
);

    logic [NUM_WF-1:0]  live;
    logic [NUM_WF-1:0]  parked;
    logic [NUM_WF-1:0]  eligible;
    logic [PC_W-1:0]    pc_q   [NUM_WF];
    logic [THREADS-1:0] mask_q [NUM_WF];

    wf_table #(.NUM_WF(NUM_WF), .PC_W(PC_W), .THREADS(THREADS)) u_table (
        .clk(clk), .rst_n(rst_n), .reset_pc(reset_pc),
        .spawn_valid(spawn_valid), .spawn_count(spawn_count), .spawn_pc(spawn_pc),
        .upd_valid(upd_valid), .upd_wf(upd_wf), .upd_pc(upd_pc),
        .live_q(live), .pc_q(pc_q), .mask_q(mask_q)
    );

    wf_barrier #(.NUM_WF(NUM_WF), .NUM_BAR(NUM_BAR)) u_barrier (
        .clk(clk), .rst_n(rst_n), .live(live),
        .bar_valid(bar_valid), .bar_wf(bar_wf), .bar_id(bar_id),
        .bar_expect(bar_expect), .parked(parked)
    );

    // Eligible contexts are live and not waiting at a barrier.
    assign eligible = live & ~parked;

    wf_rr_pick #(.NUM_WF(NUM_WF)) u_pick (
        .clk(clk), .rst_n(rst_n), .eligible(eligible), .stall(stall),
        .sel_valid(sel_valid), .sel_wf(sel_wf)
    );

    // Present the chosen context's PC and mask.
    always_comb begin
        sel_pc   = pc_q[sel_wf];
        sel_mask = mask_q[sel_wf];
    end

    // R8: under stall with unchanged eligibility the pick does not move.
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stall) && $past(rst_n) && $stable(eligible)) |-> $stable(sel_wf));

    // R5: a parked wavefront never reaches the fetch outputs.
    a_r5_parked_not_picked: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> !parked[sel_wf]);

endmodule

// File: tb/sim_wf_sched.sv
// Self-checking bench for wf_sched: directed corner cases then seeded random
// traffic, compared each cycle against a behavioural model kept in the bench.
module sim_wf_sched;

    localparam int CLK_PERIOD = 10;
    localparam int NWF        = 4;
    localparam int NBAR       = 4;
    localparam int PCW        = 32;
    localparam int THR        = 8;
    localparam int WATCHDOG   = 100000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [PCW-1:0]  reset_pc;
    logic            spawn_valid;
    logic [PCW-1:0]  spawn_count;
    logic [PCW-1:0]  spawn_pc;
    logic            bar_valid;
    logic [1:0]      bar_wf;
    logic [1:0]      bar_id;
    logic [2:0]      bar_expect;
    logic            upd_valid;
    logic [1:0]      upd_wf;
    logic [PCW-1:0]  upd_pc;
    logic            stall;
    logic            sel_valid;
    logic [1:0]      sel_wf;
    logic [PCW-1:0]  sel_pc;
    logic [THR-1:0]  sel_mask;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    // Behavioural model state.
    bit             m_live [NWF];
    logic [PCW-1:0] m_pc   [NWF];
    logic [THR-1:0] m_mask [NWF];
    bit [NWF-1:0]   m_wait [NBAR];
    int             m_cnt  [NBAR];
    int             m_last;

    wf_sched #(.NUM_WF(NWF), .NUM_BAR(NBAR), .PC_W(PCW), .THREADS(THR)) u0 (
        .clk(clk), .rst_n(rst_n), .reset_pc(reset_pc),
        .spawn_valid(spawn_valid), .spawn_count(spawn_count), .spawn_pc(spawn_pc),
        .bar_valid(bar_valid), .bar_wf(bar_wf), .bar_id(bar_id), .bar_expect(bar_expect),
        .upd_valid(upd_valid), .upd_wf(upd_wf), .upd_pc(upd_pc), .stall(stall),
        .sel_valid(sel_valid), .sel_wf(sel_wf), .sel_pc(sel_pc), .sel_mask(sel_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit [NWF-1:0] m_parked();
        bit [NWF-1:0] p = '0;
        for (int b = 0; b < NBAR; b++) p |= m_wait[b];
        return p;
    endfunction

    // Expected pick: first live, unparked slot after m_last; -1 if none.
    function automatic int m_pick();
        bit [NWF-1:0] p = m_parked();
        for (int k = 1; k <= NWF; k++) begin
            int idx = (m_last + k) % NWF;
            if (m_live[idx] && !p[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic print_summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Apply one clock edge to the model using the inputs driven before it.
    task automatic model_step();
        if (!rst_n) begin
            for (int w = 0; w < NWF; w++) begin
                m_live[w] = (w == 0);
                m_pc[w]   = (w == 0) ? reset_pc : '0;
                m_mask[w] = (w == 0) ? '1 : '0;
            end
            for (int b = 0; b < NBAR; b++) begin
                m_wait[b] = '0;
                m_cnt[b]  = 0;
            end
            m_last = NWF - 1;
        end else begin
            int pick = m_pick();
            bit [NWF-1:0] p = m_parked();
            int n;
            if (bar_valid && m_live[bar_wf] && !p[bar_wf]) begin
                if (m_cnt[bar_id] + 1 >= int'(bar_expect)) begin
                    m_wait[bar_id] = '0;
                    m_cnt[bar_id]  = 0;
                end else begin
                    m_wait[bar_id][bar_wf] = 1'b1;
                    m_cnt[bar_id]++;
                end
            end
            n = (spawn_count > PCW'(NWF)) ? NWF : int'(spawn_count);
            for (int w = 0; w < NWF; w++) begin
                if (spawn_valid && w != 0 && w < n) begin
                    m_live[w] = 1'b1;
                    m_pc[w]   = spawn_pc;
                    m_mask[w] = '1;
                end else if (upd_valid && int'(upd_wf) == w && m_live[w]) begin
                    m_pc[w] = upd_pc;
                end
            end
            if (!stall && pick >= 0) m_last = pick;
        end
    endtask

    // One cycle: edge, model update, then compare outputs at the falling edge.
    task automatic tick(input string tag);
        int p;
        @(posedge clk);
        model_step();
        @(negedge clk);
        p = m_pick();
        chk(tag, "sel_valid", 32'(sel_valid), 32'(p >= 0));
        if (p >= 0) begin
            chk(tag, "sel_wf",   32'(sel_wf),   32'(p));
            chk(tag, "sel_pc",   sel_pc,        m_pc[p]);
            chk(tag, "sel_mask", 32'(sel_mask), 32'(m_mask[p]));
        end
    endtask

    task automatic clr();
        spawn_valid = 0; spawn_count = '0; spawn_pc = '0;
        bar_valid = 0; bar_wf = '0; bar_id = '0; bar_expect = '0;
        upd_valid = 0; upd_wf = '0; upd_pc = '0; stall = 0;
    endtask

    task automatic barrier(input int wf, input int id, input int expct);
        clr();
        bar_valid = 1; bar_wf = 2'(wf); bar_id = 2'(id); bar_expect = 3'(expct);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
            print_summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clr();
        rst_n = 0;
        reset_pc = 32'h0000_1000;
        @(negedge clk);
        tick("R1");
        tick("R1");
        rst_n = 1;
        tick("R1");
        chk("R1", "reset pc",   sel_pc, 32'h0000_1000);
        chk("R1", "reset wf",   32'(sel_wf), 32'd0);
        chk("R1", "reset mask", 32'(sel_mask), 32'hff);

        // R3: oversized spawn count fills the table.
        spawn_valid = 1; spawn_count = 32'd9; spawn_pc = 32'h100;
        tick("R3");
        clr();
        for (int i = 0; i < 5; i++) tick("R7");

        // R8: stall freezes the rotation.
        stall = 1;
        for (int i = 0; i < 3; i++) tick("R8");
        clr();

        // R4: PC update on a live context.
        upd_valid = 1; upd_wf = 2'd2; upd_pc = 32'h200;
        tick("R4");

        // R5, R10, R6: barrier id 1 expecting three arrivals.
        barrier(0, 1, 3); tick("R5");
        barrier(0, 1, 3); tick("R10");
        barrier(1, 1, 3); tick("R5");
        barrier(2, 1, 3); tick("R6");
        clr();
        for (int i = 0; i < 4; i++) tick("R7");
        // R6: counter restarted, so one arrival of two only parks.
        barrier(3, 1, 2); tick("R6");
        barrier(0, 1, 2); tick("R6");
        clr();
        tick("R6");

        // Fresh start for spawn corner cases.
        rst_n = 0; tick("R1"); rst_n = 1;
        spawn_valid = 1; spawn_count = 32'd0; spawn_pc = 32'h300;
        tick("R2");
        clr();
        spawn_valid = 1; spawn_count = 32'd2; spawn_pc = 32'h300;
        upd_valid = 1; upd_wf = 2'd1; upd_pc = 32'h444;
        tick("R2");
        clr();
        upd_valid = 1; upd_wf = 2'd3; upd_pc = 32'h555;
        tick("R4");
        barrier(3, 0, 4); tick("R10");
        barrier(0, 0, 4); tick("R5");
        barrier(1, 0, 4); tick("R9");
        clr();
        tick("R9");
        chk("R9", "idle", 32'(sel_valid), 32'd0);

        // Random traffic with periodic reset.
        for (int i = 0; i < 3000; i++) begin
            int p = m_pick();
            clr();
            rst_n = !(i % 400 == 399);
            if ($urandom_range(0, 29) == 0) begin
                spawn_valid = 1;
                spawn_count = 32'($urandom_range(0, 9));
                spawn_pc    = $urandom & 32'hffff_fffc;
            end
            if ($urandom_range(0, 2) != 0) begin
                upd_valid = 1;
                upd_wf    = 2'($urandom_range(0, 3));
                upd_pc    = $urandom;
            end
            if ($urandom_range(0, 5) == 0) begin
                bar_valid  = 1;
                bar_wf     = (p >= 0 && $urandom_range(0, 3) != 0) ? 2'(p)
                                                                   : 2'($urandom_range(0, 3));
                bar_id     = 2'($urandom_range(0, 1));
                bar_expect = 3'($urandom_range(1, 4));
            end
            stall = ($urandom_range(0, 7) == 0);
            tick("R7");
        end
        clr();
        print_summary();
    end

endmodule